// File: doc/BRIEF.md
# Round-Robin Block-to-Lane Distributor

This block takes a group of parallel user streams, each producing one block per block period, and carries them over a smaller set of serial lanes. Each block is delimited by start and end markers. The block does not stripe streams across lanes. Instead it gathers the blocks of every stream that belong to one time step and sends them back to back on a single lane. Each new time step moves to the next lane in turn. The lane for step t is t modulo the lane count. Every lane therefore carries bursts of blocks, and several lanes can drain their bursts at the same time.

Each input stream writes into its own buffer. A single dispatcher walks the streams in index order for the current step. It moves one word per cycle from the selected input buffer into the buffer of the current lane. Each lane buffer holds one full burst and feeds that lane's output port. All data ports use valid/ready handshakes. A word moves only on a cycle where valid and ready are both high. An input's ready goes low only when its buffer is full. A lane output holds its word and markers while its ready is low. A stall on one lane holds back the dispatcher only when the dispatcher needs to write to that lane and the lane's buffer is full.

Top module: `lane_rotator`

## Requirements
- R1: After reset all lane_valid bits are 0, all in_ready bits are 1, and the schedule starts at step 0: lane 0, stream 0.
- R2: Within a step, streams are taken in index order 0 to NS-1. No word of stream k is forwarded before the word with in_eop=1 of stream k-1 has been moved. A block waiting on a later stream stays in its input buffer.
- R3: All blocks of step t leave on lane t mod NL, where steps count from 0 after reset. The lane pointer advances, wrapping from NL-1 to 0, only when the end word of stream NS-1 has been moved.
- R4: Every word leaves with its data, sop flag and eop flag unchanged and in input order. On a lane, the blocks of a step appear in the order stream 0, 1, ..., NS-1.
- R5: Each input buffer holds NL*BLK_LEN words. in_ready goes low only when that buffer is full, and it only falls in the cycle after a word was accepted on that input.
- R6: While lane_valid is 1 and lane_ready is 0, the next cycle keeps lane_valid at 1 and keeps lane_data, lane_sop and lane_eop unchanged.
- R7: Lanes drain independently. A lane held at lane_ready=0 does not stop later steps from appearing on other lanes while its own buffer still has room.
- R8: Each lane buffer holds NS*BLK_LEN words, one full burst. With every lane stalled, NL complete steps are absorbed by the lane buffers and NL more fill the input buffers, after which every in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NS | Per-stream word valid |
| in_ready | output | NS | Per-stream ready; low when that input buffer is full |
| in_data | input | NS*DW | Per-stream data; stream s in bits [s*DW +: DW] |
| in_sop | input | NS | Per-stream first word of a block |
| in_eop | input | NS | Per-stream last word of a block |
| lane_valid | output | NL | Per-lane word valid |
| lane_ready | input | NL | Per-lane ready from the serial side |
| lane_data | output | NL*DW | Per-lane data; lane l in bits [l*DW +: DW] |
| lane_sop | output | NL | Per-lane first word of a block |
| lane_eop | output | NL | Per-lane last word of a block |

## Verification
The assertions check several rules on every cycle:
- A lane word stays put while its lane is stalled.
- An input's ready falls only right after a push.
- The stream pointer moves only on an end word.
- The lane pointer steps by one, with wrap, only when the last stream of a step completes.
- The outputs are idle just after reset.

Some behaviour only the directed scenarios can show. These are the actual lane mapping of steps and the exact words, markers and stream order within each burst. They also include the exact input buffer capacity, independent draining of lanes under a stall, and the point where all inputs back up once every lane buffer is full.

// File: rtl/lr_pkg.sv
package lr_pkg;
  // Index width for a count of n items, at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lr_fifo.sv
module lr_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_word,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_word
);
  localparam int AW = lr_pkg::idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign pop_valid  = (cnt_q != '0);
  assign pop_word   = mem[rd_q];
  assign push       = push_valid & push_ready;
  assign pop        = pop_valid & pop_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/lr_sched.sv
module lr_sched #(
  parameter int NS      = 4,
  parameter int NL      = 3,
  parameter int W       = 18,
  parameter int EOP_BIT = 16,
  localparam int SW     = lr_pkg::idx_w(NS),
  localparam int LW     = lr_pkg::idx_w(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0]   src_valid,
  input  logic [NS*W-1:0] src_word,
  output logic [NS-1:0]   src_ready,
  output logic [NL-1:0]   dst_valid,
  output logic [NL*W-1:0] dst_word,
  input  logic [NL-1:0]   dst_ready,
  output logic [SW-1:0]   cur_str,
  output logic [LW-1:0]   cur_lane,
  output logic            blk_end
);
  logic [SW-1:0] str_q;
  logic [LW-1:0] lane_q;
  logic          sel_valid, space, move, last_str;
  logic [W-1:0]  sel_word;

  always_comb begin
    sel_valid = src_valid[str_q];
    sel_word  = src_word[str_q*W +: W];
    space     = dst_ready[lane_q];
    move      = sel_valid & space;
    src_ready = '0;
    src_ready[str_q] = space;
    dst_valid = '0;
    dst_valid[lane_q] = sel_valid;
  end

  // The word goes to every lane buffer; only the selected one sees valid.
  for (genvar l = 0; l < NL; l++) begin : g_bcast
    assign dst_word[l*W +: W] = sel_word;
  end

  assign last_str = (str_q == SW'(NS - 1));
  assign blk_end  = move & sel_word[EOP_BIT];
  assign cur_str  = str_q;
  assign cur_lane = lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q  <= '0;
      lane_q <= '0;
    end else if (blk_end) begin
      str_q <= last_str ? '0 : str_q + 1'b1;
      if (last_str)
        lane_q <= (lane_q == LW'(NL - 1)) ? '0 : lane_q + 1'b1;
    end
  end
endmodule

// File: rtl/lane_rotator.sv
module lane_rotator #(
  parameter int NS      = 4,
  parameter int NL      = 3,
  parameter int DW      = 16,
  parameter int BLK_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    in_valid,
  output logic [NS-1:0]    in_ready,
  input  logic [NS*DW-1:0] in_data,
  input  logic [NS-1:0]    in_sop,
  input  logic [NS-1:0]    in_eop,
  output logic [NL-1:0]    lane_valid,
  input  logic [NL-1:0]    lane_ready,
  output logic [NL*DW-1:0] lane_data,
  output logic [NL-1:0]    lane_sop,
  output logic [NL-1:0]    lane_eop
);
  localparam int W          = DW + 2;
  localparam int EOP_BIT    = DW;
  localparam int SOP_BIT    = DW + 1;
  localparam int IN_DEPTH   = NL * BLK_LEN;
  localparam int LANE_DEPTH = NS * BLK_LEN;
  localparam int SW         = lr_pkg::idx_w(NS);
  localparam int LW         = lr_pkg::idx_w(NL);

  logic [NS-1:0]   q_valid, q_ready;
  logic [NS*W-1:0] q_word;
  logic [NL-1:0]   d_valid, d_ready;
  logic [NL*W-1:0] d_word;
  logic [SW-1:0]   sched_str;
  logic [LW-1:0]   sched_lane;
  logic            sched_blk_end;

  for (genvar s = 0; s < NS; s++) begin : g_in
    lr_fifo #(.W(W), .DEPTH(IN_DEPTH)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[s]),
      .push_ready (in_ready[s]),
      .push_word  ({in_sop[s], in_eop[s], in_data[s*DW +: DW]}),
      .pop_valid  (q_valid[s]),
      .pop_ready  (q_ready[s]),
      .pop_word   (q_word[s*W +: W])
    );
  end

  lr_sched #(.NS(NS), .NL(NL), .W(W), .EOP_BIT(EOP_BIT)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (q_valid),
    .src_word  (q_word),
    .src_ready (q_ready),
    .dst_valid (d_valid),
    .dst_word  (d_word),
    .dst_ready (d_ready),
    .cur_str   (sched_str),
    .cur_lane  (sched_lane),
    .blk_end   (sched_blk_end)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [W-1:0] out_w;
    lr_fifo #(.W(W), .DEPTH(LANE_DEPTH)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (d_valid[l]),
      .push_ready (d_ready[l]),
      .push_word  (d_word[l*W +: W]),
      .pop_valid  (lane_valid[l]),
      .pop_ready  (lane_ready[l]),
      .pop_word   (out_w)
    );
    assign lane_data[l*DW +: DW] = out_w[DW-1:0];
    assign lane_sop[l]           = out_w[SOP_BIT];
    assign lane_eop[l]           = out_w[EOP_BIT];
  end
endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
  parameter int NS = 4,
  parameter int NL = 3,
  parameter int DW = 16,
  localparam int SW = lr_pkg::idx_w(NS),
  localparam int LW = lr_pkg::idx_w(NL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NS-1:0]    in_valid,
  input logic [NS-1:0]    in_ready,
  input logic [NL-1:0]    lane_valid,
  input logic [NL-1:0]    lane_ready,
  input logic [NL*DW-1:0] lane_data,
  input logic [NL-1:0]    lane_sop,
  input logic [NL-1:0]    lane_eop,
  input logic [SW-1:0]    cur_str,
  input logic [LW-1:0]    cur_lane,
  input logic             blk_end
);
  // R1: idle outputs and start position right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lane_valid == '0) && (cur_str == '0) && (cur_lane == '0));

  // R2: stream pointer moves only after an end word was moved
  a_r2_stream_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_str != $past(cur_str)) |-> $past(blk_end));

  // R3: lane pointer steps by one with wrap, only at the end of the last stream
  a_r3_lane_steps_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lane != $past(cur_lane)) |->
      $past(blk_end) && ($past(cur_str) == SW'(NS - 1)) &&
      (cur_lane == (($past(cur_lane) == LW'(NL - 1)) ? LW'(0) : $past(cur_lane) + LW'(1))));

  a_r3_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lane < LW'(NL));

  for (genvar s = 0; s < NS; s++) begin : g_in_chk
    // R5: ready falls only after a word was pushed on that input
    a_r5_ready_falls_on_push: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready[s] && $past(in_ready[s])) |-> $past(in_valid[s]));
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane_chk
    // R6: stalled lane word holds
    a_r6_hold_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[l] && !lane_ready[l]) |=>
        lane_valid[l] && $stable(lane_data[l*DW +: DW]) &&
        $stable(lane_sop[l]) && $stable(lane_eop[l]));
  end
endmodule

bind lane_rotator lr_checker #(.NS(NS), .NL(NL), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lane_valid (lane_valid),
  .lane_ready (lane_ready),
  .lane_data  (lane_data),
  .lane_sop   (lane_sop),
  .lane_eop   (lane_eop),
  .cur_str    (sched_str),
  .cur_lane   (sched_lane),
  .blk_end    (sched_blk_end)
);

// File: tb/lane_rotator_tb.sv
module lane_rotator_tb;
  localparam int NS  = 4;
  localparam int NL  = 3;
  localparam int DW  = 16;
  localparam int BLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0]    in_valid, in_ready, in_sop, in_eop;
  logic [NS*DW-1:0] in_data;
  logic [NL-1:0]    lane_valid, lane_ready, lane_sop, lane_eop;
  logic [NL*DW-1:0] lane_data;

  logic          iv   [NS];
  logic          isop [NS];
  logic          ieop [NS];
  logic [DW-1:0] id   [NS];
  logic          lr   [NL];

  for (genvar s = 0; s < NS; s++) begin : g_drv
    assign in_valid[s]         = iv[s];
    assign in_sop[s]           = isop[s];
    assign in_eop[s]           = ieop[s];
    assign in_data[s*DW +: DW] = id[s];
  end
  for (genvar l = 0; l < NL; l++) begin : g_lr
    assign lane_ready[l] = lr[l];
  end

  lane_rotator #(.NS(NS), .NL(NL), .DW(DW), .BLK_LEN(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_data(lane_data),
    .lane_sop(lane_sop), .lane_eop(lane_eop)
  );

  // Lane monitor: records every accepted word as {sop, eop, data}
  logic [DW+1:0] got [NL][256];
  int            gn  [NL];
  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) gn[l] <= 0;
      else if (lane_valid[l] && lane_ready[l] && gn[l] < 256) begin
        got[l][gn[l]] <= {lane_sop[l], lane_eop[l], lane_data[l*DW +: DW]};
        gn[l] <= gn[l] + 1;
      end
    end
  end

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wval(input int t, input int s, input int w);
    return DW'((t << 8) | (s << 4) | w);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    for (int s = 0; s < NS; s++) begin iv[s] = 0; isop[s] = 0; ieop[s] = 0; id[s] = '0; end
    for (int l = 0; l < NL; l++) lr[l] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_block(input int s, input int t);
    for (int w = 0; w < BLK; w++) begin
      @(negedge clk);
      iv[s] = 1; id[s] = wval(t, s, w); isop[s] = (w == 0); ieop[s] = (w == BLK - 1);
      while (!in_ready[s]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    iv[s] = 0;
  endtask

  task automatic send_stream(input int s, input int t0, input int n);
    for (int t = t0; t < t0 + n; t++) send_block(s, t);
  endtask

  task automatic send_steps(input int t0, input int n);
    for (int s = 0; s < NS; s++) begin
      automatic int ss = s;
      fork
        send_stream(ss, t0, n);
      join_none
    end
    wait fork;
  endtask

  // Compare lane contents with steps 0..n-1, step t on lane t mod NL
  task automatic check_lanes(input int n, input string req);
    int pi [NL];
    for (int l = 0; l < NL; l++) pi[l] = 0;
    for (int t = 0; t < n; t++) begin
      automatic int l = t % NL;
      for (int s = 0; s < NS; s++) begin
        automatic bit ok = 1;
        automatic int bad_act = 0, bad_exp = 0;
        for (int w = 0; w < BLK; w++) begin
          automatic logic [DW+1:0] e = {w == 0, w == BLK - 1, wval(t, s, w)};
          automatic logic [DW+1:0] a = (pi[l] < gn[l]) ? got[l][pi[l]] : '1;
          if (ok && a !== e) begin ok = 0; bad_act = int'(a); bad_exp = int'(e); end
          pi[l]++;
        end
        check(ok, req, bad_act, bad_exp);
      end
    end
    for (int l = 0; l < NL; l++) check(gn[l] == pi[l], {req, " word count"}, gn[l], pi[l]);
  endtask

  task automatic t_reset();
    do_reset();
    check(lane_valid == '0, "R1 lane_valid", int'(lane_valid), 0);
    check(in_ready == '1, "R1 in_ready", int'(in_ready), (1 << NS) - 1);
  endtask

  task automatic t_basic();
    do_reset();
    send_steps(0, 6);
    repeat (200) @(negedge clk);
    check_lanes(6, "R3 R4 rotation");
  endtask

  task automatic t_order();
    do_reset();
    send_block(3, 0);
    repeat (40) @(negedge clk);
    check(gn[0] + gn[1] + gn[2] == 0, "R2 stream3 held", gn[0] + gn[1] + gn[2], 0);
    check(lane_valid == '0, "R2 lanes idle", int'(lane_valid), 0);
    fork
      send_block(0, 0);
      send_block(1, 0);
      send_block(2, 0);
    join
    repeat (80) @(negedge clk);
    check_lanes(1, "R2 order");
  endtask

  task automatic t_fill();
    int acc = 0;
    do_reset();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      iv[1] = 1; id[1] = wval(0, 1, k % BLK); isop[1] = 0; ieop[1] = 0;
      if (!in_ready[1]) break;
      @(posedge clk);
      acc++;
    end
    @(negedge clk);
    iv[1] = 0;
    check(acc == NL * BLK, "R5 input depth", acc, NL * BLK);
    check(in_ready[1] == 1'b0, "R5 ready low when full", int'(in_ready[1]), 0);
    check(in_ready[0] == 1'b1, "R5 other input ready", int'(in_ready[0]), 1);
    check(lane_valid == '0, "R2 later stream waits", int'(lane_valid), 0);
  endtask

  task automatic t_stall();
    logic [DW-1:0] d0;
    do_reset();
    for (int l = 0; l < NL; l++) lr[l] = 1'b0;
    send_steps(0, 2);
    repeat (80) @(negedge clk);
    d0 = lane_data[0 +: DW];
    check(lane_valid[0] && lane_sop[0] && d0 == wval(0, 0, 0), "R6 lane0 head", int'(d0), int'(wval(0, 0, 0)));
    repeat (5) @(negedge clk);
    check(lane_valid[0] && lane_data[0 +: DW] == d0, "R6 lane0 held", int'(lane_data[0 +: DW]), int'(d0));
    check(lane_valid[1] && lane_data[DW +: DW] == wval(1, 0, 0), "R7 lane1 served during stall",
          int'(lane_data[DW +: DW]), int'(wval(1, 0, 0)));
    check(lane_valid[2] == 1'b0, "R3 lane2 unused", int'(lane_valid[2]), 0);
    lr[1] = 1'b1;
    repeat (60) @(negedge clk);
    check(gn[1] == NS * BLK && gn[0] == 0, "R7 lane1 drained alone", gn[1] * 1000 + gn[0], NS * BLK * 1000);
    lr[0] = 1'b1;
    repeat (60) @(negedge clk);
    check_lanes(2, "R6 R7 contents");
  endtask

  task automatic t_burst();
    do_reset();
    for (int l = 0; l < NL; l++) lr[l] = 1'b0;
    send_steps(0, 2 * NL);
    repeat (20) @(negedge clk);
    check(in_ready == '0, "R8 inputs full", int'(in_ready), 0);
    check(lane_valid == '1, "R8 all lanes hold a burst", int'(lane_valid), (1 << NL) - 1);
    for (int l = 0; l < NL; l++) lr[l] = 1'b1;
    repeat (400) @(negedge clk);
    check_lanes(2 * NL, "R8 contents");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_fill();
    t_stall();
    t_burst();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule